// File: doc/BRIEF.md
# GPIO Pin Bank Controller

A bank of general-purpose I/O pins. Each pin owns one byte-wide control/status register on a simple synchronous register bus made of an address, a write strobe, write data and combinational read data. The register picks whether the pin is an input, an output or an alternate-function pin, and it reports the pin's live level together with a sticky edge flag.

An input pin is first passed through a two-flop synchroniser. It can then be debounced against a sample tick, inverted by a polarity bit, and watched for its active transition, which sets a flag that software clears by writing one to it. The conditioned level, or the flag in its place, is delivered on a per-pin output to the logic that consumes it. An output pin drives a constant low, a constant high, or one of two clock inputs. An alternate-function pin passes a per-pin source input to the pad. The pad is modelled as separate input, output and output-enable vectors.

Top module: `gpio_bank`

## Requirements
- R1: The register for pin i is at byte address BASE_ADDR + i (0x10 + i by default). A read from any address outside the bank returns 0x00, a write outside the bank changes nothing, and bit 7 of every register reads 0.
- R2: After reset every register reads 0x00: input mode, debounce off, flag clear, sub-field 00. All output enables and pad outputs are 0.
- R3: Bit 5 is read-only and reads the pad level after two flops, so it follows padIn two rising clock edges later. Writes to bit 5 are ignored.
- R4: Bit 4 (debounce enable), bits 3:2 (mode) and bits 1:0 (sub-field) read back exactly as last written.
- R5: Mode 01 (output) enables the pad driver. Sub-field 00 drives 0, 01 drives 1, 10 drives clkA and 11 drives clkB.
- R6: Mode 10 (alternate function) enables the pad driver and drives altIn for that pin, whatever the value of the sub-field.
- R7: Mode 00 (input) and the reserved mode 11 keep the pad driver disabled with padOut at 0. Both act as input modes.
- R8: In an input mode, bit 6 is set on an active transition of the effective input. The transition is rising when sub-field bit 0 is 1 and falling when it is 0. The flag holds until a write with bit 6 = 1 clears it. Writing 0 to bit 6 leaves it as it is. When a set and a clear fall in the same cycle, the flag ends up set.
- R9: With bit 4 set, the effective input takes a new synchronised level only after that level has differed from the current one for DB_TICKS sampleTick pulses in a row (4 by default). A shorter excursion is dropped, and with no tick pulses the level is held. With bit 4 clear, the synchronised level is used directly.
- R10: In an input mode, pinVal is the effective input when sub-field bit 1 is 0, inverted when sub-field bit 0 is 0. When sub-field bit 1 is 1, pinVal is the edge flag. In the other modes pinVal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte address |
| regWe | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr, combinational |
| sampleTick | input | 1 | Debounce sample pulse |
| padIn | input | NUM_PINS | Asynchronous pad levels |
| altIn | input | NUM_PINS | Alternate-function sources |
| clkA | input | 1 | First selectable output clock |
| clkB | input | 1 | Second selectable output clock |
| padOut | output | NUM_PINS | Pad output values |
| padOe | output | NUM_PINS | Pad output enables |
| pinVal | output | NUM_PINS | Conditioned input or edge flag per pin |

## Verification
A wrong mode or sub-field register shows at the pad one cycle after the write, as a wrong padOe or padOut bit, and it reads back wrong at once. A broken synchroniser or debounce counter moves the bit 5 read or pinVal earlier or later than the two-edge and DB_TICKS-tick windows allow, so samples taken just inside and just outside those windows expose it. A bad edge detector or clear priority leaves bit 6 wrong on the next read. The case where a clear lands in the same cycle as a set event is driven on the exact cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    MODE_IN   = 2'b00,
    MODE_OUT  = 2'b01,
    MODE_ALT  = 2'b10,
    MODE_RSVD = 2'b11
  } pinMode_e;

  // Strobes passed from the bus decoder to the pin datapath.
  typedef struct packed {
    logic       wrStb;
    logic       rdHit;
    logic [7:0] wdata;
  } regStb_t;

  localparam int FLAG_BIT = 6;
  localparam int LIVE_BIT = 5;
  localparam int DBEN_BIT = 4;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter int BASE_ADDR = 16,
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output regStb_t           stb,
  output logic [IDX_W-1:0]  pinSel
);

  logic [ADDR_W-1:0] offs;
  logic              inBank;

  always_comb begin
    offs   = regAddr - ADDR_W'(BASE_ADDR);
    inBank = (regAddr >= ADDR_W'(BASE_ADDR)) && (offs < ADDR_W'(NUM_PINS));
    pinSel = offs[IDX_W-1:0];
    stb.wrStb = regWe && inBank;
    stb.rdHit = inBank;
    stb.wdata = regWdata;
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DB_TICKS = 4,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStb_t             stb,
  input  logic [IDX_W-1:0]    pinSel,
  input  logic                sampleTick,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] altIn,
  input  logic                clkA,
  input  logic                clkB,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] pinVal,
  output logic [7:0]          regRdata
);

  localparam int CNT_W = $clog2(DB_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(DB_TICKS - 1);

  logic [7:0] rdByte [NUM_PINS];

  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    logic [1:0]       syncQ;
    logic             dbLvl;
    logic [CNT_W-1:0] dbCnt;
    logic             effPrev;
    logic             flagQ;
    logic             dbEn;
    pinMode_e         modeQ;
    logic [1:0]       subQ;
    logic             wrMe, eff, isIn, cond, setEv;
    logic             oeBit, outBit;

    assign wrMe = stb.wrStb && (pinSel == IDX_W'(i));

    // two-flop synchroniser
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[0], padIn[i]};
    end

    // debounce: count ticks while the synchronised level differs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dbLvl <= 1'b0;
        dbCnt <= '0;
      end else if (syncQ[1] == dbLvl) begin
        dbCnt <= '0;
      end else if (sampleTick) begin
        if (dbCnt == CNT_LIM) begin
          dbLvl <= syncQ[1];
          dbCnt <= '0;
        end else begin
          dbCnt <= dbCnt + 1'b1;
        end
      end
    end

    assign eff   = dbEn ? dbLvl : syncQ[1];
    assign isIn  = (modeQ == MODE_IN) || (modeQ == MODE_RSVD);
    assign cond  = subQ[0] ? eff : ~eff;
    assign setEv = isIn && (subQ[0] ? (eff && !effPrev) : (!eff && effPrev));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        effPrev <= 1'b0;
        flagQ   <= 1'b0;
        dbEn    <= 1'b0;
        modeQ   <= MODE_IN;
        subQ    <= 2'b00;
      end else begin
        effPrev <= eff;
        if (wrMe) begin
          dbEn  <= stb.wdata[DBEN_BIT];
          modeQ <= pinMode_e'(stb.wdata[3:2]);
          subQ  <= stb.wdata[1:0];
        end
        if (setEv)                            flagQ <= 1'b1;
        else if (wrMe && stb.wdata[FLAG_BIT]) flagQ <= 1'b0;
      end
    end

    always_comb begin
      oeBit  = 1'b0;
      outBit = 1'b0;
      case (modeQ)
        MODE_OUT: begin
          oeBit = 1'b1;
          case (subQ)
            2'b00:   outBit = 1'b0;
            2'b01:   outBit = 1'b1;
            2'b10:   outBit = clkA;
            default: outBit = clkB;
          endcase
        end
        MODE_ALT: begin
          oeBit  = 1'b1;
          outBit = altIn[i];
        end
        default: begin
          oeBit  = 1'b0;
          outBit = 1'b0;
        end
      endcase
    end

    assign padOe[i]  = oeBit;
    assign padOut[i] = outBit;
    assign pinVal[i] = isIn ? (subQ[1] ? flagQ : cond) : 1'b0;
    assign rdByte[i] = {1'b0, flagQ, syncQ[1], dbEn, modeQ, subQ};
  end

  assign regRdata = stb.rdHit ? rdByte[pinSel] : 8'h00;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter int BASE_ADDR = 16,
  parameter int ADDR_W    = 8,
  parameter int DB_TICKS  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWe,
  input  logic [7:0]          regWdata,
  output logic [7:0]          regRdata,
  input  logic                sampleTick,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] altIn,
  input  logic                clkA,
  input  logic                clkB,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] pinVal
);

  localparam int IDX_W = $clog2(NUM_PINS);

  regStb_t          stb;
  logic [IDX_W-1:0] pinSel;

  gpio_ctrl #(
    .NUM_PINS(NUM_PINS), .BASE_ADDR(BASE_ADDR), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) uCtrl (
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .stb(stb), .pinSel(pinSel)
  );

  gpio_datapath #(
    .NUM_PINS(NUM_PINS), .DB_TICKS(DB_TICKS), .IDX_W(IDX_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .pinSel(pinSel),
    .sampleTick(sampleTick), .padIn(padIn), .altIn(altIn),
    .clkA(clkA), .clkB(clkB), .padOut(padOut), .padOe(padOe),
    .pinVal(pinVal), .regRdata(regRdata)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS  = 32,
  parameter int BASE_ADDR = 16,
  parameter int ADDR_W    = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWe,
  input logic [7:0]          regWdata,
  input logic [7:0]          regRdata,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[7] == 1'b0); // R1

  for (genvar k = 0; k < NUM_PINS; k++) begin : gChk
    logic wrK;
    assign wrK = regWe && (regAddr == ADDR_W'(BASE_ADDR + k));

    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
      wrK && (regWdata[3:2] == 2'b00 || regWdata[3:2] == 2'b11) |=> !padOe[k]); // R7

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
      !padOe[k] |-> !padOut[k]); // R7

    AST_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      wrK && regWdata[3:0] == 4'b0101 |=> padOe[k] && padOut[k]); // R5

    AST_LIVE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst >= 2'd2) && (regAddr == ADDR_W'(BASE_ADDR + k))
        |-> regRdata[5] == $past(padIn[k], 2)); // R3
  end

endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PINS(NUM_PINS), .BASE_ADDR(BASE_ADDR), .ADDR_W(ADDR_W)
) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
  .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn),
  .padOut(padOut), .padOe(padOe)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWe = 1'b0;
  logic [7:0]  regWdata = 8'h00;
  logic [7:0]  regRdata;
  logic        sampleTick = 1'b1;
  logic [31:0] padIn = 32'h0;
  logic [31:0] altIn = 32'hA5A5_A5A5;
  logic        clkA = 1'b1;
  logic        clkB = 1'b0;
  logic [31:0] padOut, padOe, pinVal;

  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .sampleTick(sampleTick),
    .padIn(padIn), .altIn(altIn), .clkA(clkA), .clkB(clkB),
    .padOut(padOut), .padOe(padOe), .pinVal(pinVal)
  );

  // {pin, write data, expected read, expected oe, expected out}
  localparam logic [22:0] VEC [9] = '{
    {5'd0,  8'h04, 8'h04, 1'b1, 1'b0},
    {5'd1,  8'h05, 8'h05, 1'b1, 1'b1},
    {5'd2,  8'h06, 8'h06, 1'b1, 1'b1},
    {5'd6,  8'h07, 8'h07, 1'b1, 1'b0},
    {5'd7,  8'h08, 8'h08, 1'b1, 1'b1},
    {5'd8,  8'h09, 8'h09, 1'b1, 1'b1},
    {5'd9,  8'h0C, 8'h0C, 1'b0, 1'b0},
    {5'd10, 8'h3D, 8'h1D, 1'b0, 1'b0},
    {5'd11, 8'h0A, 8'h0A, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrAddr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic wrPin(input int pin, input logic [7:0] d);
    wrAddr(8'(8'h10 + pin), d);
  endtask

  task automatic rdAddr(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic rdPin(input int pin, output logic [7:0] d);
    rdAddr(8'(8'h10 + pin), d);
  endtask

  task automatic finishRun;
    $display("  TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [7:0]  d;
    logic [31:0] oeSnap;
    settle(3);
    rstN = 1'b1;
    settle(3);

    // R2 reset state
    for (int p = 0; p < 32; p++) begin
      rdPin(p, d);
      check("R2 reset register", 32'(d), 32'h00);
    end
    check("R2 reset padOe", padOe, 32'h0);
    check("R2 reset padOut", padOut, 32'h0);
    check("R10 reset pinVal active-low idle", pinVal, 32'hFFFF_FFFF);

    // R1 outside the bank
    rdAddr(8'h0F, d);
    check("R1 read below bank", 32'(d), 32'h00);
    rdAddr(8'h30, d);
    check("R1 read above bank", 32'(d), 32'h00);

    // table walk: modes and drive selection (R4 R5 R6 R7 R3)
    for (int v = 0; v < 9; v++) begin
      logic [22:0] e;
      e = VEC[v];
      wrPin(int'(e[22:18]), e[17:10]);
      rdPin(int'(e[22:18]), d);
      check("R4 readback", 32'(d), 32'(e[9:2]));
      check("R5/R6/R7 padOe", 32'(padOe[e[22:18]]), 32'(e[1]));
      check("R5/R6/R7 padOut", 32'(padOut[e[22:18]]), 32'(e[0]));
    end
    clkA = 1'b0;
    #1 check("R5 clkA follows", 32'(padOut[2]), 32'h0);
    clkB = 1'b1;
    #1 check("R5 clkB follows", 32'(padOut[6]), 32'h1);
    check("R10 output pin pinVal", 32'(pinVal[0]), 32'h0);

    // R1 writes outside the bank change nothing
    oeSnap = padOe;
    wrAddr(8'h0F, 8'h05);
    wrAddr(8'h30, 8'h05);
    check("R1 stray write padOe", padOe, oeSnap);
    rdPin(12, d);
    check("R1 stray write neighbour", 32'(d), 32'h00);

    // R8 rising-edge flag on pin 3
    wrPin(3, 8'h01);
    @(negedge clk); padIn[3] = 1'b1;
    settle(4);
    rdPin(3, d);
    check("R8 rising sets flag", 32'(d), 32'h61);
    check("R10 direct active-high", 32'(pinVal[3]), 32'h1);
    wrPin(3, 8'h03);
    rdPin(3, d);
    check("R8 write zero keeps flag", 32'(d), 32'h63);
    check("R10 flag selected", 32'(pinVal[3]), 32'h1);
    wrPin(3, 8'h43);
    rdPin(3, d);
    check("R8 write one clears", 32'(d), 32'h23);
    check("R10 flag cleared", 32'(pinVal[3]), 32'h0);
    @(negedge clk); padIn[3] = 1'b0;
    settle(4);
    rdPin(3, d);
    check("R8 falling ignored active-high", 32'(d), 32'h03);

    // R8 set beats clear in the same cycle
    @(negedge clk); padIn[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regAddr = 8'h13; regWdata = 8'h43; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    rdPin(3, d);
    check("R8 set wins over clear", 32'(d), 32'h63);

    // R8 R10 active-low on pin 4 (reset config)
    @(negedge clk); padIn[4] = 1'b1;
    settle(4);
    check("R10 active-low inverted", 32'(pinVal[4]), 32'h0);
    rdPin(4, d);
    check("R8 rising ignored active-low", 32'(d), 32'h20);
    @(negedge clk); padIn[4] = 1'b0;
    settle(4);
    rdPin(4, d);
    check("R8 falling sets active-low", 32'(d), 32'h40);

    // R9 debounce on pin 5
    wrPin(5, 8'h11);
    @(negedge clk); padIn[5] = 1'b1;
    settle(2);
    padIn[5] = 1'b0;
    settle(8);
    check("R9 glitch rejected", 32'(pinVal[5]), 32'h0);
    rdPin(5, d);
    check("R9 glitch no flag", 32'(d), 32'h11);
    @(negedge clk); padIn[5] = 1'b1;
    settle(3);
    check("R9 not yet accepted", 32'(pinVal[5]), 32'h0);
    settle(9);
    check("R9 accepted", 32'(pinVal[5]), 32'h1);
    rdPin(5, d);
    check("R9 R8 debounced edge flag", 32'(d), 32'h71);
    sampleTick = 1'b0;
    @(negedge clk); padIn[5] = 1'b0;
    settle(10);
    check("R9 held without ticks", 32'(pinVal[5]), 32'h1);
    sampleTick = 1'b1;
    settle(8);
    check("R9 released with ticks", 32'(pinVal[5]), 32'h0);

    // R3 live bit timing, no debounce
    @(negedge clk); padIn[13] = 1'b1; regAddr = 8'h1D;
    @(negedge clk);
    #1 check("R3 one edge not visible", 32'(regRdata[5]), 32'h0);
    @(negedge clk);
    #1 check("R3 two edges visible", 32'(regRdata[5]), 32'h1);

    finishRun();
  end

endmodule